// File: doc/BRIEF.md
# Set/Clear-Masked Interrupt Controller

This block collects a fixed set of interrupt sources (sixteen by default) and drives a single interrupt request line towards a small processor. A source becomes pending once its input is active and every enable that governs it is switched on. Each source is governed by one bit in a mask register and by one multi-bit field in a priority register. Each priority field covers a group of neighbouring sources, and a nonzero field enables the whole group. The mask registers are held as pairs of addresses. Writing ones to the set address turns bits on, and writing ones to the clear address turns them off. The priority registers are plain read/write registers.

The processor reads the pending source back as a vector code. It supplies its current 4-bit interrupt mask level, and the block answers with the code of the lowest-numbered pending source, together with a valid flag. A 4-bit inverted level input drives a chain of fifteen sources. At most one of them is active at a time, and it is ORed with the discrete source inputs. Registers are reached through a simple single-cycle bus. Only the low 29 address bits are decoded, so every register is visible in several aliased address windows.

Top module: `setclr_intc`

## Requirements
- R1: After reset, every mask and priority register reads zero, and `irq_o`, `vec_vld_o` and `vec_o` are all zero.
- R2: A write to mask pair r at its set address (default 0x0400_0040 + 4r) ORs the low data bits into the stored value. A read of either address of the pair returns the stored value, zero-extended.
- R3: A write to the clear address of mask pair r (default 0x0400_0060 + 4r) stores the old value AND NOT the low data bits.
- R4: A write to priority register p (default 0x0400_0000 + 4p) overwrites it with the low 16 data bits. Field k, counting from 0, occupies bits [(3-k)*4+3 : (3-k)*4] and governs group g = 4p + k.
- R5: Source s is pending exactly when its input is active, its mask bit is 1, and its group's priority field is nonzero. The mask bit sits in pair r = s/8 at bit 7 - (s mod 8).
- R6: `irq_o` is high exactly when at least one source is pending. It is registered, so a register write that changes it shows up one clock after the write edge, and an input change shows up at the next rising edge.
- R7: Only address bits [28:0] are decoded. An address differing only in bits [31:29] reaches the same register for both reads and writes.
- R8: A write to an unmapped or misaligned address changes no register. A read of such an address returns zero.
- R9: When the mask level is 0xF, `vec_vld_o` is 0 and `vec_o` is 0. Otherwise `vec_vld_o` follows `irq_o`, and `vec_o` is 0x200 + 0x20*s for the lowest-numbered pending source s.
- R10: A level input L from 1 to 15 activates chain source L XOR 15, which is one of sources 0 to 14. Level 0 activates none of them.
- R11: A single priority field enables or disables both sources of its group, 2g and 2g+1, together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_i | input | 16 | Discrete interrupt source inputs, active high |
| lvl_i | input | 4 | Inverted level input for the source chain |
| imask_i | input | 4 | Processor interrupt mask level |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 32 | Register byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i`, combinational |
| irq_o | output | 1 | Interrupt request to the processor |
| vec_o | output | 12 | Vector code of the selected pending source |
| vec_vld_o | output | 1 | Vector valid |

## Verification
Several properties are checked on every cycle. The set and clear writes must leave the written bits on or off on the following read of the same address. Unmapped reads must return zero. A quiet input set must never raise the request. The valid flag must agree with the request line, and must drop whenever the mask level is 0xF. Any valid vector code must fall on the code grid. Some behaviours can only be shown by the bench's sweeps against its arithmetic model: the field order inside a priority register, the grouping of two sources per field, the bit order of the mask pairs, the scan order between several pending sources, the level decode and the exact one-clock latency.

// File: rtl/setclr_intc_pkg.sv
package setclr_intc_pkg;

   localparam int unsigned IDX_W = 8;

   typedef enum logic [1:0] {
      WM_NONE = 2'd0,
      WM_SET  = 2'd1,
      WM_CLR  = 2'd2,
      WM_PRIO = 2'd3
   } wmode_t;

   typedef struct packed {
      wmode_t            mode;
      logic [IDX_W-1:0]  idx;
   } regsel_t;

endpackage

// File: rtl/setclr_intc_decode.sv
module setclr_intc_decode
   import setclr_intc_pkg::*;
#(
   parameter logic [31:0] MSET_BASE = 32'h0400_0040,
   parameter logic [31:0] MCLR_BASE = 32'h0400_0060,
   parameter logic [31:0] PRIO_BASE = 32'h0400_0000,
   parameter int unsigned MASK_REGS = 2,
   parameter int unsigned PRIO_REGS = 2
) (
   input  logic [31:0] addr_i,
   output regsel_t     sel_o
);
   localparam int unsigned DEC_W = 29;

   logic [DEC_W-1:0] a;
   logic [DEC_W-1:0] off_set, off_clr, off_pri;
   logic             hit_set, hit_clr, hit_pri;

   assign a       = addr_i[DEC_W-1:0];
   assign off_set = a - MSET_BASE[DEC_W-1:0];
   assign off_clr = a - MCLR_BASE[DEC_W-1:0];
   assign off_pri = a - PRIO_BASE[DEC_W-1:0];

   assign hit_set = (a >= MSET_BASE[DEC_W-1:0]) && (off_set[1:0] == 2'b00)
                    && (off_set[DEC_W-1:2] < (DEC_W-2)'(MASK_REGS));
   assign hit_clr = (a >= MCLR_BASE[DEC_W-1:0]) && (off_clr[1:0] == 2'b00)
                    && (off_clr[DEC_W-1:2] < (DEC_W-2)'(MASK_REGS));
   assign hit_pri = (a >= PRIO_BASE[DEC_W-1:0]) && (off_pri[1:0] == 2'b00)
                    && (off_pri[DEC_W-1:2] < (DEC_W-2)'(PRIO_REGS));

   always_comb begin
      sel_o = '{mode: WM_NONE, idx: '0};
      if (hit_set) begin
         sel_o.mode = WM_SET;
         sel_o.idx  = off_set[IDX_W+1:2];
      end else if (hit_clr) begin
         sel_o.mode = WM_CLR;
         sel_o.idx  = off_clr[IDX_W+1:2];
      end else if (hit_pri) begin
         sel_o.mode = WM_PRIO;
         sel_o.idx  = off_pri[IDX_W+1:2];
      end
   end
endmodule

// File: rtl/setclr_intc_mask_bank.sv
module setclr_intc_mask_bank
   import setclr_intc_pkg::*;
#(
   parameter int unsigned N_REGS = 2,
   parameter int unsigned REG_W  = 8,
   localparam int unsigned N_BITS = N_REGS * REG_W
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we_i,
   input  regsel_t                       sel_i,
   input  logic [REG_W-1:0]              wdata_i,
   output logic [N_REGS-1:0][REG_W-1:0]  val_o,
   output logic [N_BITS-1:0]             en_o
);
   for (genvar r = 0; r < N_REGS; r++) begin : g_reg
      logic hit;
      assign hit = we_i && (sel_i.idx == IDX_W'(r));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            val_o[r] <= '0;
         end else if (hit && sel_i.mode == WM_SET) begin
            val_o[r] <= val_o[r] | wdata_i;
         end else if (hit && sel_i.mode == WM_CLR) begin
            val_o[r] <= val_o[r] & ~wdata_i;
         end
      end

      // first listed source in the most significant bit
      for (genvar k = 0; k < REG_W; k++) begin : g_bit
         assign en_o[r*REG_W + k] = val_o[r][REG_W-1-k];
      end
   end
endmodule

// File: rtl/setclr_intc_prio_bank.sv
module setclr_intc_prio_bank
   import setclr_intc_pkg::*;
#(
   parameter int unsigned N_REGS   = 2,
   parameter int unsigned FIELD_W  = 4,
   parameter int unsigned FIELDS   = 4,
   parameter int unsigned GROUP_SZ = 2,
   localparam int unsigned REG_W   = FIELD_W * FIELDS,
   localparam int unsigned N_GRP   = N_REGS * FIELDS,
   localparam int unsigned N_SRC   = N_GRP * GROUP_SZ
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          we_i,
   input  regsel_t                       sel_i,
   input  logic [REG_W-1:0]              wdata_i,
   output logic [N_REGS-1:0][REG_W-1:0]  val_o,
   output logic [N_SRC-1:0]              en_o
);
   logic [N_GRP-1:0] grp_en;

   for (genvar r = 0; r < N_REGS; r++) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            val_o[r] <= '0;
         end else if (we_i && sel_i.mode == WM_PRIO && sel_i.idx == IDX_W'(r)) begin
            val_o[r] <= wdata_i;
         end
      end

      for (genvar k = 0; k < FIELDS; k++) begin : g_fld
         assign grp_en[r*FIELDS + k] = |val_o[r][(FIELDS-1-k)*FIELD_W +: FIELD_W];
      end
   end

   for (genvar g = 0; g < N_GRP; g++) begin : g_grp
      for (genvar m = 0; m < GROUP_SZ; m++) begin : g_mem
         assign en_o[g*GROUP_SZ + m] = grp_en[g];
      end
   end
endmodule

// File: rtl/setclr_intc_lvl_chain.sv
module setclr_intc_lvl_chain #(
   parameter int unsigned N_SRC = 16,
   parameter int unsigned LVL_W = 4,
   localparam int unsigned CHAIN = (1 << LVL_W) - 1
) (
   input  logic [LVL_W-1:0] lvl_i,
   output logic [N_SRC-1:0] act_o
);
   logic [LVL_W-1:0] sel;
   assign sel = lvl_i ^ {LVL_W{1'b1}};

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      if (i < CHAIN) begin : g_chain
         assign act_o[i] = (sel == LVL_W'(i));
      end else begin : g_free
         assign act_o[i] = 1'b0;
      end
   end
endmodule

// File: rtl/setclr_intc_scan.sv
module setclr_intc_scan #(
   parameter int unsigned N_SRC    = 16,
   parameter int unsigned VEC_W    = 12,
   parameter int unsigned VEC_BASE = 'h200,
   parameter int unsigned VEC_STEP = 'h20,
   parameter int unsigned MASK_W   = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  pend_i,
   input  logic [MASK_W-1:0] imask_i,
   output logic              irq_o,
   output logic [VEC_W-1:0]  vec_o,
   output logic              vec_vld_o
);
   localparam int unsigned SEL_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

   logic [SEL_W-1:0] first;
   logic             any;
   logic             blocked;
   logic [VEC_W-1:0] code;

   always_comb begin
      first = '0;
      for (int i = N_SRC - 1; i >= 0; i--) begin
         if (pend_i[i]) first = SEL_W'(i);
      end
   end

   assign any     = |pend_i;
   assign blocked = (imask_i == {MASK_W{1'b1}});
   assign code    = VEC_W'(VEC_BASE) + VEC_W'(first) * VEC_W'(VEC_STEP);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_o     <= 1'b0;
         vec_vld_o <= 1'b0;
         vec_o     <= '0;
      end else begin
         irq_o     <= any;
         vec_vld_o <= any && !blocked;
         vec_o     <= (any && !blocked) ? code : '0;
      end
   end
endmodule

// File: rtl/setclr_intc.sv
module setclr_intc
   import setclr_intc_pkg::*;
#(
   parameter int unsigned N_SRC       = 16,
   parameter int unsigned MASK_REGS   = 2,
   parameter int unsigned MASK_W      = 8,
   parameter int unsigned PRIO_REGS   = 2,
   parameter int unsigned PRIO_FW     = 4,
   parameter int unsigned PRIO_FIELDS = 4,
   parameter int unsigned GROUP_SZ    = 2,
   parameter int unsigned LVL_W       = 4,
   parameter int unsigned VEC_W       = 12,
   parameter int unsigned VEC_BASE    = 'h200,
   parameter int unsigned VEC_STEP    = 'h20,
   parameter logic [31:0] MSET_BASE   = 32'h0400_0040,
   parameter logic [31:0] MCLR_BASE   = 32'h0400_0060,
   parameter logic [31:0] PRIO_BASE   = 32'h0400_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_SRC-1:0]  src_i,
   input  logic [LVL_W-1:0]  lvl_i,
   input  logic [3:0]        imask_i,
   input  logic              bus_we_i,
   input  logic [31:0]       bus_addr_i,
   input  logic [31:0]       bus_wdata_i,
   output logic [31:0]       bus_rdata_o,
   output logic              irq_o,
   output logic [VEC_W-1:0]  vec_o,
   output logic              vec_vld_o
);
   localparam int unsigned PRIO_W = PRIO_FW * PRIO_FIELDS;
   localparam int unsigned MIDX_W = (MASK_REGS > 1) ? $clog2(MASK_REGS) : 1;
   localparam int unsigned PIDX_W = (PRIO_REGS > 1) ? $clog2(PRIO_REGS) : 1;

   if (N_SRC != MASK_REGS * MASK_W) begin : g_bad_mask
      $error("mask bits must cover every source exactly once");
   end
   if (N_SRC != PRIO_REGS * PRIO_FIELDS * GROUP_SZ) begin : g_bad_prio
      $error("priority groups must cover every source exactly once");
   end
   if (N_SRC < (1 << LVL_W) - 1) begin : g_bad_chain
      $error("level chain needs more sources");
   end
   if (PRIO_W > 32 || MASK_W > 32) begin : g_bad_width
      $error("register wider than the bus");
   end
   if (MASK_REGS > 256 || PRIO_REGS > 256) begin : g_bad_count
      $error("too many registers for the select index");
   end

   regsel_t                              sel;
   logic [MASK_REGS-1:0][MASK_W-1:0]     mask_val;
   logic [PRIO_REGS-1:0][PRIO_W-1:0]     prio_val;
   logic [N_SRC-1:0]                     mask_en, prio_en, chain_act, pend;

   setclr_intc_decode #(
      .MSET_BASE (MSET_BASE),
      .MCLR_BASE (MCLR_BASE),
      .PRIO_BASE (PRIO_BASE),
      .MASK_REGS (MASK_REGS),
      .PRIO_REGS (PRIO_REGS)
   ) u_decode (
      .addr_i (bus_addr_i),
      .sel_o  (sel)
   );

   setclr_intc_mask_bank #(
      .N_REGS (MASK_REGS),
      .REG_W  (MASK_W)
   ) u_mask (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (bus_we_i),
      .sel_i   (sel),
      .wdata_i (bus_wdata_i[MASK_W-1:0]),
      .val_o   (mask_val),
      .en_o    (mask_en)
   );

   setclr_intc_prio_bank #(
      .N_REGS   (PRIO_REGS),
      .FIELD_W  (PRIO_FW),
      .FIELDS   (PRIO_FIELDS),
      .GROUP_SZ (GROUP_SZ)
   ) u_prio (
      .clk     (clk),
      .rst_n   (rst_n),
      .we_i    (bus_we_i),
      .sel_i   (sel),
      .wdata_i (bus_wdata_i[PRIO_W-1:0]),
      .val_o   (prio_val),
      .en_o    (prio_en)
   );

   setclr_intc_lvl_chain #(
      .N_SRC (N_SRC),
      .LVL_W (LVL_W)
   ) u_chain (
      .lvl_i (lvl_i),
      .act_o (chain_act)
   );

   assign pend = (src_i | chain_act) & mask_en & prio_en;

   setclr_intc_scan #(
      .N_SRC    (N_SRC),
      .VEC_W    (VEC_W),
      .VEC_BASE (VEC_BASE),
      .VEC_STEP (VEC_STEP),
      .MASK_W   (4)
   ) u_scan (
      .clk       (clk),
      .rst_n     (rst_n),
      .pend_i    (pend),
      .imask_i   (imask_i),
      .irq_o     (irq_o),
      .vec_o     (vec_o),
      .vec_vld_o (vec_vld_o)
   );

   always_comb begin
      bus_rdata_o = '0;
      case (sel.mode)
         WM_SET, WM_CLR: bus_rdata_o = 32'(mask_val[sel.idx[MIDX_W-1:0]]);
         WM_PRIO:        bus_rdata_o = 32'(prio_val[sel.idx[PIDX_W-1:0]]);
         default:        bus_rdata_o = '0;
      endcase
   end
endmodule

// File: rtl/setclr_intc_chk.sv
module setclr_intc_chk #(
   parameter int unsigned N_SRC     = 16,
   parameter int unsigned MASK_REGS = 2,
   parameter int unsigned MASK_W    = 8,
   parameter int unsigned PRIO_REGS = 2,
   parameter int unsigned LVL_W     = 4,
   parameter int unsigned VEC_W     = 12,
   parameter int unsigned VEC_BASE  = 'h200,
   parameter int unsigned VEC_STEP  = 'h20,
   parameter logic [31:0] MSET_BASE = 32'h0400_0040,
   parameter logic [31:0] MCLR_BASE = 32'h0400_0060,
   parameter logic [31:0] PRIO_BASE = 32'h0400_0000
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N_SRC-1:0]  src_i,
   input logic [LVL_W-1:0]  lvl_i,
   input logic [3:0]        imask_i,
   input logic              bus_we_i,
   input logic [31:0]       bus_addr_i,
   input logic [31:0]       bus_wdata_i,
   input logic [31:0]       bus_rdata_o,
   input logic              irq_o,
   input logic [VEC_W-1:0]  vec_o,
   input logic              vec_vld_o
);
   logic [28:0]      a;
   logic             in_set, in_clr, in_pri;
   logic [VEC_W-1:0] vdiff;

   assign a      = bus_addr_i[28:0];
   assign in_set = (a[1:0] == 2'b00) && (a >= MSET_BASE[28:0])
                   && (a < MSET_BASE[28:0] + 29'(4*MASK_REGS));
   assign in_clr = (a[1:0] == 2'b00) && (a >= MCLR_BASE[28:0])
                   && (a < MCLR_BASE[28:0] + 29'(4*MASK_REGS));
   assign in_pri = (a[1:0] == 2'b00) && (a >= PRIO_BASE[28:0])
                   && (a < PRIO_BASE[28:0] + 29'(4*PRIO_REGS));
   assign vdiff  = vec_o - VEC_W'(VEC_BASE);

   AST_SET_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we_i && in_set) |=> (!$stable(bus_addr_i) ||
         ((bus_rdata_o[MASK_W-1:0] & $past(bus_wdata_i[MASK_W-1:0])) == $past(bus_wdata_i[MASK_W-1:0])))); // R2

   AST_CLR_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_we_i && in_clr) |=> (!$stable(bus_addr_i) ||
         ((bus_rdata_o[MASK_W-1:0] & $past(bus_wdata_i[MASK_W-1:0])) == '0))); // R3

   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_set || in_clr || in_pri) |-> (bus_rdata_o == '0)); // R8

   AST_QUIET_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      ((src_i == '0) && (lvl_i == '0)) |=> !irq_o); // R5

   AST_VLD_TRACKS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (imask_i != 4'hF) |=> (vec_vld_o == irq_o)); // R6

   AST_MASKED_NO_VEC: assert property (@(posedge clk) disable iff (!rst_n)
      (imask_i == 4'hF) |=> (!vec_vld_o && vec_o == '0)); // R9

   AST_VEC_ON_GRID: assert property (@(posedge clk) disable iff (!rst_n)
      vec_vld_o |-> ((vdiff % VEC_W'(VEC_STEP)) == '0 && (vdiff / VEC_W'(VEC_STEP)) < VEC_W'(N_SRC))); // R9
endmodule

bind setclr_intc setclr_intc_chk #(
   .N_SRC     (N_SRC),
   .MASK_REGS (MASK_REGS),
   .MASK_W    (MASK_W),
   .PRIO_REGS (PRIO_REGS),
   .LVL_W     (LVL_W),
   .VEC_W     (VEC_W),
   .VEC_BASE  (VEC_BASE),
   .VEC_STEP  (VEC_STEP),
   .MSET_BASE (MSET_BASE),
   .MCLR_BASE (MCLR_BASE),
   .PRIO_BASE (PRIO_BASE)
) u_setclr_intc_chk (.*);

// File: tb/test_setclr_intc.sv
module test_setclr_intc;
   localparam logic [31:0] MSET = 32'h0400_0040;
   localparam logic [31:0] MCLR = 32'h0400_0060;
   localparam logic [31:0] PRIO = 32'h0400_0000;

   logic        clk = 1'b0;
   logic        rst_n;
   logic [15:0] src_i;
   logic [3:0]  lvl_i, imask_i;
   logic        bus_we_i;
   logic [31:0] bus_addr_i, bus_wdata_i, bus_rdata_o;
   logic        irq_o, vec_vld_o;
   logic [11:0] vec_o;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [7:0]  m_mask [2];
   logic [15:0] m_prio [2];

   always #5 clk = ~clk;

   setclr_intc i_setclr_intc (
      .clk(clk), .rst_n(rst_n), .src_i(src_i), .lvl_i(lvl_i), .imask_i(imask_i),
      .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
      .bus_rdata_o(bus_rdata_o), .irq_o(irq_o), .vec_o(vec_o), .vec_vld_o(vec_vld_o)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(logic [31:0] addr, logic [31:0] data);
      @(negedge clk);
      bus_addr_i = addr; bus_wdata_i = data; bus_we_i = 1'b1;
      @(negedge clk);
      bus_we_i = 1'b0;
   endtask

   task automatic rd(logic [31:0] addr, output logic [31:0] data);
      @(negedge clk);
      bus_addr_i = addr;
      #1 data = bus_rdata_o;
   endtask

   task automatic settle();
      @(negedge clk);
   endtask

   // expected pending from the requirement arithmetic
   function automatic logic [15:0] exp_pend();
      logic [15:0] p = '0;
      for (int s = 0; s < 16; s++) begin
         logic act  = src_i[s] || (lvl_i != 0 && (lvl_i ^ 4'hF) == 4'(s));
         logic mbit = m_mask[s/8][7 - (s % 8)];
         int   g    = s / 2;
         logic pf   = (((m_prio[g/4] >> ((3 - (g % 4)) * 4)) & 16'hF) != 0);
         p[s] = act && mbit && pf;
      end
      return p;
   endfunction

   task automatic check_out(string req);
      logic [15:0] p = exp_pend();
      logic        e_irq = |p;
      logic        e_vld = e_irq && (imask_i != 4'hF);
      logic [11:0] e_vec = '0;
      if (e_vld) begin
         for (int s = 15; s >= 0; s--) if (p[s]) e_vec = 12'(12'h200 + 12'h20 * s);
      end
      check(req, {18'd0, irq_o, vec_vld_o, vec_o}, {18'd0, e_irq, e_vld, e_vec});
   endtask

   task automatic check_regs(string req);
      logic [31:0] d;
      for (int r = 0; r < 2; r++) begin
         rd(MSET + 32'(4*r), d); check(req, d, 32'(m_mask[r]));
         rd(MCLR + 32'(4*r), d); check(req, d, 32'(m_mask[r]));
         rd(PRIO + 32'(4*r), d); check(req, d, 32'(m_prio[r]));
      end
   endtask

   task automatic mset(int r, logic [7:0] v);
      wr(MSET + 32'(4*r), {24'hABCDEF, v}); m_mask[r] = m_mask[r] | v;
   endtask
   task automatic mclr(int r, logic [7:0] v);
      wr(MCLR + 32'(4*r), {24'h123456, v}); m_mask[r] = m_mask[r] & ~v;
   endtask
   task automatic pset(int r, logic [15:0] v);
      wr(PRIO + 32'(4*r), {16'hFFFF, v}); m_prio[r] = v;
   endtask

   task automatic report();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog actual=running expected=finished");
         report();
      end
   end

   initial begin
      logic [31:0] d;
      rst_n = 1'b0; src_i = '0; lvl_i = '0; imask_i = '0;
      bus_we_i = 1'b0; bus_addr_i = '0; bus_wdata_i = '0;
      m_mask[0] = '0; m_mask[1] = '0; m_prio[0] = '0; m_prio[1] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      settle();

      // R1 reset state
      check_out("R1 outputs after reset");
      check_regs("R1 registers after reset");

      // R2 / R3 set and clear sweep on both pairs
      for (int r = 0; r < 2; r++) begin
         for (int v = 0; v < 256; v += 17) begin
            mset(r, 8'(v));
            rd(MSET + 32'(4*r), d); check("R2 set readback", d, 32'(m_mask[r]));
            rd(MCLR + 32'(4*r), d); check("R2 clear-address readback", d, 32'(m_mask[r]));
            mclr(r, 8'(v * 3 + 5));
            rd(MSET + 32'(4*r), d); check("R3 clear result", d, 32'(m_mask[r]));
         end
      end

      // R4 overwrite
      pset(0, 16'h1234); pset(1, 16'hBEEF);
      check_regs("R4 priority readback");
      pset(1, 16'h0000);
      check_regs("R4 priority overwrite");

      // R4 / R11 field order and grouping: one field at a time, every source
      mset(0, 8'hFF); mset(1, 8'hFF);
      for (int g = 0; g < 8; g++) begin
         pset(0, 16'h0); pset(1, 16'h0);
         pset(g / 4, 16'((g % 15 + 1) << ((3 - (g % 4)) * 4)));
         for (int s = 0; s < 16; s++) begin
            src_i = 16'(1 << s);
            settle();
            check_out("R4 R11 field governs group");
         end
      end
      src_i = '0;

      // R5 mask bit order: drop one bit at a time
      pset(0, 16'h1111); pset(1, 16'h1111);
      for (int s = 0; s < 16; s++) begin
         mset(0, 8'hFF); mset(1, 8'hFF);
         mclr(s / 8, 8'(1 << (7 - (s % 8))));
         src_i = 16'hFFFF; settle();
         check_out("R5 all inputs, one mask bit off");
         src_i = 16'(1 << s); settle();
         check_out("R5 single input, its mask bit off");
      end
      mset(0, 8'hFF); mset(1, 8'hFF);

      // R9 scan order and mask level
      for (int pi = 0; pi < 6; pi++) begin
         logic [15:0] pats [6] = '{16'h8000, 16'h0101, 16'hF0F0, 16'h0006, 16'hFFFF, 16'h0000};
         src_i = pats[pi];
         for (int m = 0; m < 16; m++) begin
            imask_i = 4'(m); settle();
            check_out("R9 vector under mask level");
         end
      end
      imask_i = 4'h3;

      // R10 level chain alone and mixed with discrete inputs
      src_i = '0;
      for (int l = 0; l < 16; l++) begin
         lvl_i = 4'(l); settle();
         check_out("R10 level selects chain source");
      end
      src_i = 16'h8000;
      for (int l = 0; l < 16; l++) begin
         lvl_i = 4'(l); settle();
         check_out("R10 level with discrete input");
      end
      lvl_i = '0;

      // R6 latency of the request after a write
      mclr(0, 8'hFF); mclr(1, 8'hFF);
      src_i = 16'h0010; settle();
      check_out("R6 request low when masked");
      mset(0, 8'h08);
      check("R6 request one clock after write, not yet", 32'(irq_o), 32'd0);
      settle();
      check("R6 request one clock after write", 32'(irq_o), 32'd1);
      mclr(0, 8'h08);
      check("R6 request still high on write edge", 32'(irq_o), 32'd1);
      settle();
      check("R6 request drops after clear", 32'(irq_o), 32'd0);

      // R7 aliased windows
      wr(32'hA400_0044, 32'h0000_00C3); m_mask[1] = m_mask[1] | 8'hC3;
      rd(32'h0400_0044, d); check("R7 alias write, base read", d, 32'(m_mask[1]));
      rd(32'hE400_0064, d); check("R7 alias read of clear address", d, 32'(m_mask[1]));
      wr(32'h8400_0004, 32'h0000_5A5A); m_prio[1] = 16'h5A5A;
      rd(32'h2400_0004, d); check("R7 alias priority", d, 32'h5A5A);

      // R8 unmapped and misaligned accesses
      wr(32'h0400_0048, 32'hFFFF_FFFF);
      wr(32'h0400_0042, 32'hFFFF_FFFF);
      wr(32'h0400_0080, 32'h0000_0000);
      wr(32'h0400_0008, 32'h0000_0000);
      check_regs("R8 unmapped write ignored");
      rd(32'h0400_0048, d); check("R8 unmapped read", d, 32'd0);
      rd(32'h0400_0061, d); check("R8 misaligned read", d, 32'd0);
      settle();
      check_out("R8 outputs unchanged");

      done = 1'b1;
      report();
   end
endmodule